// File: doc/BRIEF.md
# Self-Correcting Decoded Decade Ring Counter

This block counts in decimal using a five-stage twisted ring. On every enabled clock the ring shifts one place toward its top bit. The bit fed into the bottom stage is normally the inverse of the top stage. That gives ten distinct ring codes for the digits 0 to 9. Each code is turned into one of ten output lines, and each line uses a single two-input AND of a pair of ring bits. A one-cycle carry marks the wrap from 9 back to 0.

The bottom-stage feedback is changed in one way. A one is only shifted in when the bottom stage already holds a one, or when every lower stage is clear. Legal codes follow the same sequence as a plain twisted ring. Any of the 22 codes outside that sequence drains into the legal sequence within five enabled clocks, and no reset is needed for this.

The update is a small state machine with three named steps, chosen each cycle:
- **STEP_CLEAR**: active while the synchronous reset is high. It loads the all-zero code and clears the carry.
- **STEP_ADVANCE**: active while enabled. It shifts the ring with the corrected feedback and registers the carry.
- **STEP_HOLD**: active otherwise. It keeps the ring unchanged and drops the carry.

The ring codes for digits 0 through 9, written with the top bit first, are `ZERO` 00000, 00001, 00011, 00111, 01111, `FULL` 11111, 11110, 11100, 11000 and `LAST` 10000. After `LAST` the ring returns to `ZERO`.

Top module: `decade_ring`

## Requirements
- R1: When `rst_i` is high at a clock edge, the ring is loaded with 00000 whatever `cnt_en_i` is. After that edge `digit_o` equals 10'b0000000001 (digit 0) and `carry_o` is 0.
- R2: In a legal state, each edge with `cnt_en_i` high advances the digit by one, and 9 is followed by 0. Bit k of `digit_o` is the only line high while the count is k.
- R3: In any of the 22 codes outside the legal sequence, `digit_o` has at least three lines high.
- R4: At an edge with `cnt_en_i` low and reset low, the ring is unchanged and `carry_o` is 0 afterwards. This holds for legal and illegal codes alike.
- R5: `carry_o` is high for exactly the one cycle after an enabled edge that moves the count from 9 to 0. At all other times it is low, including after a reset taken at digit 9.
- R6: From any illegal code, `digit_o` becomes one-hot within five enabled edges, and counting then continues in the legal order. `carry_o` stays low while the ring recovers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable, active high |
| digit_o | output | 10 | Decoded decimal lines, bit k means digit k |
| carry_o | output | 1 | One-cycle pulse following the 9-to-0 step |

## Verification
The assertions assume the ring changes only through the clocked update. A code outside the legal sequence may appear, but it is not followed by a step between two legal codes that differs from a shift. The stepping property is stated only across two consecutive one-hot states. The bench plants each illegal code by briefly overriding the ring register with the enable high. It always plants from a state that did not just produce a carry, so no carry or hold property sees an override it could not cause. Enable values are drawn at random with a fixed seed. Resets, a reset at digit 9, and every illegal code are applied as directed cases.

// File: rtl/decade_ring_pkg.sv
`timescale 1ns/1ps
package decade_ring_pkg;

    // Per-cycle action selected for the ring register.
    typedef enum logic [1:0] {
        STEP_HOLD    = 2'b00,
        STEP_ADVANCE = 2'b01,
        STEP_CLEAR   = 2'b10
    } step_e;

endpackage

// File: rtl/decade_ring_next.sv
`timescale 1ns/1ps
module decade_ring_next #(
    parameter int RING_W = 5
) (
    input  logic [RING_W-1:0] ring_i,
    output logic [RING_W-1:0] ring_o
);

    logic mid_clear;
    logic feed;

    // A one enters only next to an existing one at the bottom, or into an
    // otherwise empty low part, so stray ones cannot start a second run.
    assign mid_clear = ~(|ring_i[RING_W-2:1]);
    assign feed      = ~ring_i[RING_W-1] & (ring_i[0] | mid_clear);
    assign ring_o    = {ring_i[RING_W-2:0], feed};

endmodule

// File: rtl/decade_ring_decode.sv
`timescale 1ns/1ps
module decade_ring_decode #(
    parameter  int RING_W  = 5,
    localparam int NUM_DIG = 2 * RING_W
) (
    input  logic [RING_W-1:0]  ring_i,
    output logic [NUM_DIG-1:0] dig_o
);

    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
        if (i == 0) begin : g_empty
            assign dig_o[i] = ~ring_i[RING_W-1] & ~ring_i[0];
        end else if (i < RING_W) begin : g_grow
            assign dig_o[i] = ring_i[i-1] & ~ring_i[i];
        end else if (i == RING_W) begin : g_full
            assign dig_o[i] = ring_i[RING_W-1] & ring_i[0];
        end else begin : g_shrink
            assign dig_o[i] = ~ring_i[i-RING_W-1] & ring_i[i-RING_W];
        end
    end

endmodule

// File: rtl/decade_ring.sv
`timescale 1ns/1ps
module decade_ring
    import decade_ring_pkg::*;
#(
    parameter  int RING_W  = 5,
    localparam int NUM_DIG = 2 * RING_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cnt_en_i,
    output logic [NUM_DIG-1:0] digit_o,
    output logic               carry_o
);

    localparam logic [RING_W-1:0] LAST_CODE = {1'b1, {(RING_W-1){1'b0}}};

    step_e             step;
    logic [RING_W-1:0] state_q;
    logic [RING_W-1:0] state_adv;
    logic              carry_q;

    always_comb begin
        if (rst_i) begin
            step = STEP_CLEAR;
        end else if (cnt_en_i) begin
            step = STEP_ADVANCE;
        end else begin
            step = STEP_HOLD;
        end
    end

    decade_ring_next #(.RING_W(RING_W)) u_next (
        .ring_i (state_q),
        .ring_o (state_adv)
    );

    // State register.
    always_ff @(posedge clk_i) begin
        unique case (step)
            STEP_CLEAR:   state_q <= '0;
            STEP_ADVANCE: state_q <= state_adv;
            STEP_HOLD:    state_q <= state_q;
            default:      state_q <= '0;
        endcase
    end

    // Output register: carry marks the step out of the last code.
    always_ff @(posedge clk_i) begin
        unique case (step)
            STEP_CLEAR:   carry_q <= 1'b0;
            STEP_ADVANCE: carry_q <= (state_q == LAST_CODE);
            STEP_HOLD:    carry_q <= 1'b0;
            default:      carry_q <= 1'b0;
        endcase
    end

    decade_ring_decode #(.RING_W(RING_W)) u_decode (
        .ring_i (state_q),
        .dig_o  (digit_o)
    );

    assign carry_o = carry_q;

endmodule

// File: rtl/decade_ring_chk.sv
`timescale 1ns/1ps
module decade_ring_chk #(
    parameter  int RING_W  = 5,
    localparam int NUM_DIG = 2 * RING_W
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               cnt_en_i,
    input logic [NUM_DIG-1:0] digit_o,
    input logic               carry_o
);

    localparam int CNT_W = $clog2(RING_W + 2) + 1;
    localparam logic [NUM_DIG-1:0] DIG_ZERO = NUM_DIG'(1);
    localparam logic [NUM_DIG-1:0] DIG_LAST = NUM_DIG'(1) << (NUM_DIG - 1);

    // Enabled edges taken in a row from non-one-hot outputs.
    logic [CNT_W-1:0] bad_run;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bad_run <= '0;
        end else if ($onehot(digit_o)) begin
            bad_run <= '0;
        end else if (cnt_en_i && (bad_run <= CNT_W'(RING_W))) begin
            bad_run <= bad_run + 1'b1;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk_i)
        rst_i |=> (digit_o == DIG_ZERO) && !carry_o);

    p_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) && $past(cnt_en_i) && $past($onehot(digit_o)) && $onehot(digit_o)
        |-> digit_o == {$past(digit_o[NUM_DIG-2:0]), $past(digit_o[NUM_DIG-1])});

    p_illegal_lines_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$onehot(digit_o) |-> $countones(digit_o) >= 3);

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !cnt_en_i |=> $stable(digit_o) && !carry_o);

    p_carry_set_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_en_i && (digit_o == DIG_LAST) |=> carry_o);

    p_carry_only_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_o |-> $past(cnt_en_i) && (digit_o == DIG_ZERO));

    p_recover_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        bad_run <= CNT_W'(RING_W));

endmodule

bind decade_ring decade_ring_chk #(.RING_W(RING_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_en_i (cnt_en_i),
    .digit_o  (digit_o),
    .carry_o  (carry_o)
);

// File: tb/test_decade_ring.sv
`timescale 1ns/1ps
module test_decade_ring;

    localparam int W = 5;
    localparam int N = 2 * W;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         cnt_en_i = 1'b0;
    logic [N-1:0] digit_o;
    logic         carry_o;

    int           errors = 0;
    int           checks = 0;
    int           mdl = 0;
    logic         mcarry = 1'b0;
    logic [W-1:0] inj = '0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    decade_ring #(.RING_W(W)) i_decade_ring (
        .clk_i    (clk),
        .rst_i    (rst_i),
        .cnt_en_i (cnt_en_i),
        .digit_o  (digit_o),
        .carry_o  (carry_o)
    );

    function automatic logic [W-1:0] code_of(int k);
        if (k <= W) return W'((1 << k) - 1);
        return W'(((1 << W) - 1) << (k - W));
    endfunction

    function automatic bit is_legal(logic [W-1:0] v);
        for (int k = 0; k < N; k++) if (code_of(k) == v) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [N-1:0] line_of(int k);
        return N'(1) << k;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock with the given enable; model updated per R2/R4/R5.
    task automatic tick(bit e);
        cnt_en_i = e;
        @(posedge clk);
        if (e) begin
            mcarry = (mdl == N - 1);
            mdl    = (mdl + 1) % N;
        end else begin
            mcarry = 1'b0;
        end
        @(negedge clk);
        check(e ? "R2" : "R4", "digit", 32'(digit_o), 32'(line_of(mdl)));
        check("R5", "carry", 32'(carry_o), 32'(mcarry));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        void'($urandom(32'h0000_5eed));
        rst_i    = 1'b1;
        cnt_en_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "digit after reset", 32'(digit_o), 32'(line_of(0)));
        check("R1", "carry after reset", 32'(carry_o), 32'd0);
        rst_i = 1'b0;
        mdl   = 0;

        for (int i = 0; i < 23; i++) tick(1'b1);
        for (int i = 0; i < 4; i++) tick(1'b0);

        // Reset taken at digit 9 with enable high: no carry, digit 0.
        while (mdl != N - 1) tick(1'b1);
        rst_i    = 1'b1;
        cnt_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "digit after reset at 9", 32'(digit_o), 32'(line_of(0)));
        check("R5", "carry after reset at 9", 32'(carry_o), 32'd0);
        rst_i = 1'b0;
        mdl   = 0;

        for (int i = 0; i < 3000; i++) tick($urandom_range(3, 0) != 0);

        for (int v = 0; v < (1 << W); v++) begin
            if (!is_legal(W'(v))) begin
                logic [N-1:0] snap;
                int lit;
                int steps;
                do tick(1'b1); while (mdl == 0);
                inj = W'(v);
                force i_decade_ring.state_q = inj;
                #1;
                release i_decade_ring.state_q;
                #1;
                lit = $countones(digit_o);
                checks++;
                if (lit < 3) begin
                    errors++;
                    $display("FAIL R3 lines for code %0h: actual=%0d expected>=3", v, lit);
                end
                snap     = digit_o;
                cnt_en_i = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check("R4", "illegal code held", 32'(digit_o), 32'(snap));
                check("R4", "carry while held", 32'(carry_o), 32'd0);
                steps = 0;
                while (!$onehot(digit_o) && steps < W + 2) begin
                    cnt_en_i = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    steps++;
                    check("R6", "carry during recovery", 32'(carry_o), 32'd0);
                end
                checks++;
                if (steps > W || !$onehot(digit_o)) begin
                    errors++;
                    $display("FAIL R6 recovery from %0h: actual=%0d steps expected<=%0d", v, steps, W);
                end
                for (int k = 0; k < N; k++) if (digit_o == line_of(k)) mdl = k;
                tick(1'b1); // R6: legal order resumes
                tick(1'b1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule